// File: doc/BRIEF.md
# Three-Wire Bus Ownership Controller

This block sits on the master side of a shared external bus. A central arbiter decides who owns the bus. The block talks to it over three wires: a request it raises, a grant it samples, and a bus-driven flag it asserts while it is the active master. Internal access requests arrive on a valid/ready channel. Each request carries the length of the transfer series it needs. The block asks for the bus and starts the series with a one-cycle transfer-start pulse. It counts acknowledge beats until the series ends. It also tells the address and control drivers when to drive.

The block tells apart two kinds of ownership. Implicit ownership means it holds the grant but has nothing to do, so it leaves the bus undriven. Explicit ownership means it is driving the bus. A whole series counts as one cycle, and the series cannot be interrupted. A withdrawn grant therefore takes effect only at the end of a series, and a bus-error beat also ends the series. The request channel is back-pressured: `req_ready` is high only while no accepted request is waiting to start. An offer is taken on a clock edge where both `req_valid` and `req_ready` are high. The length field is then captured and must not be relied on afterwards.

Top module: `bus_own_ctrl`

## Requirements
- R1: `bus_req` is high from the cycle after a request is accepted. It stays high through the cycle in which `xfer_start` pulses, and it falls after that cycle unless another request is waiting.
- R2: When `bus_grant` is high on a clock edge and an accepted request is waiting, the next cycle shows `xfer_start` high for exactly one cycle, with `bus_driven` high.
- R3: With `bus_grant` high and no request waiting, the block takes implicit ownership. `bus_driven`, `drive_en` and `xfer_start` all stay low.
- R4: A request accepted during implicit ownership starts on the edge after acceptance, without waiting for a fresh grant.
- R5: After a series ends with `bus_grant` still high, `bus_driven` stays high and no new `xfer_start` occurs until a request arrives.
- R6: If `bus_grant` is low on the edge where the final beat is sampled, `bus_driven` falls in the next cycle. Before that edge it stays high whatever `bus_grant` does.
- R7: `req_beats` holds the number of transfers minus one. The series ends on the (req_beats+1)-th edge with `xfer_ack` high, counting from the `xfer_start` cycle. There is exactly one `xfer_start` per series.
- R8: An edge with `xfer_err` high ends the series at once, with the same release rule as a normal final beat.
- R9: `drive_en` equals `bus_driven` in every cycle.
- R10: After reset, `bus_req`, `bus_driven`, `drive_en` and `xfer_start` are low and `req_ready` is high.
- R11: `req_ready` is low while an accepted request has not yet started, and a request offered then is not taken.
- R12: A request waiting when the final beat is sampled with `bus_grant` high starts in the very next cycle.
- R13: With the bus owned and idle, an edge with `bus_grant` low releases it. A later request then does not start until grant is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal access offer |
| req_ready | output | 1 | Offer can be taken |
| req_beats | input | BEAT_W | Transfers in the series minus one |
| bus_req | output | 1 | Request to arbiter, always driven |
| bus_grant | input | 1 | Grant from arbiter |
| bus_driven | output | 1 | Explicit mastership flag, always driven |
| xfer_start | output | 1 | One-cycle transfer-start pulse |
| xfer_ack | input | 1 | Transfer acknowledge beat |
| xfer_err | input | 1 | Error termination beat |
| drive_en | output | 1 | Enable for address, attribute and control drivers |

## Verification
Many faults in the ownership state show up within one cycle of the grant edge that exposes them. One example is a block that believes it is explicit owner while it should be implicit: `bus_driven` and `drive_en` rise with no access behind them. A block that believes it is still owner after losing grant shows up differently, as an `xfer_start` with no fresh grant. A wrong beat count shows only at the end of a series, when `bus_driven` falls one beat early or late relative to the final acknowledge. A lost waiting request shows as `bus_req` falling before any `xfer_start`, or as a back-to-back start that never comes.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [1:0] {
    OWN_NONE     = 2'd0,
    OWN_IMPLICIT = 2'd1,
    OWN_EXPLICIT = 2'd2,
    OWN_CYCLE    = 2'd3
  } own_state_t;
endpackage

// File: rtl/bus_own_slot.sv
module bus_own_slot #(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_beats,
  input  logic              take,
  output logic              pend,
  output logic [BEAT_W-1:0] pend_beats
);
  assign in_ready = !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_beats <= '0;
    end else if (in_valid && in_ready) begin
      pend       <= 1'b1;
      pend_beats <= in_beats;
    end else if (take) begin
      pend       <= 1'b0;
    end
  end

  // a waiting request is never lost or altered before it starts
  assert_slot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take |=> pend && $stable(pend_beats));
endmodule

// File: rtl/bus_own_beats.sv
module bus_own_beats #(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_cycle,
  input  logic              load,
  input  logic [BEAT_W-1:0] load_val,
  input  logic              beat,
  input  logic              abort,
  output logic              series_end
);
  logic [BEAT_W-1:0] remain;

  assign series_end = in_cycle && (abort || (beat && remain == '0));

  always_ff @(posedge clk) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= load_val;
    else if (series_end)       remain <= '0;
    else if (in_cycle && beat) remain <= remain - 1'b1;
  end

  // counter is clear whenever no series is in progress
  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cycle |-> remain == '0);
  // an ordinary beat inside a series moves the count down by one
  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_cycle && beat && !abort && remain != '0 && !load |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       pend,
  input  logic       series_end,
  output own_state_t state,
  output logic       take,
  output logic       start_q
);
  own_state_t state_nx;
  logic       boundary;

  assign boundary = (state != OWN_CYCLE) || series_end;
  assign take     = pend && grant && boundary;

  always_comb begin
    state_nx = state;
    if (boundary) begin
      if (!grant)    state_nx = OWN_NONE;
      else if (pend) state_nx = OWN_CYCLE;
      else if (state == OWN_NONE || state == OWN_IMPLICIT)
                     state_nx = OWN_IMPLICIT;
      else           state_nx = OWN_EXPLICIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= OWN_NONE;
      start_q <= 1'b0;
    end else begin
      state   <= state_nx;
      start_q <= take;
    end
  end

  assert_start_on_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(grant));
  assert_series_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == OWN_CYCLE && !series_end |=> state == OWN_CYCLE);
  assert_owned_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == OWN_EXPLICIT |-> $past(grant));
  assert_release_on_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    state != OWN_CYCLE && !grant |=> state == OWN_NONE);
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BEAT_W-1:0] req_beats,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_driven,
  output logic              xfer_start,
  input  logic              xfer_ack,
  input  logic              xfer_err,
  output logic              drive_en
);
  own_state_t        state;
  logic              pend, take, series_end;
  logic [BEAT_W-1:0] pend_beats;

  bus_own_slot #(.BEAT_W(BEAT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_beats(req_beats), .take(take), .pend(pend), .pend_beats(pend_beats)
  );

  bus_own_beats #(.BEAT_W(BEAT_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .in_cycle(state == OWN_CYCLE), .load(take),
    .load_val(pend_beats), .beat(xfer_ack), .abort(xfer_err),
    .series_end(series_end)
  );

  bus_own_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .grant(bus_grant), .pend(pend),
    .series_end(series_end), .state(state), .take(take), .start_q(xfer_start)
  );

  assign bus_req    = pend || xfer_start;
  assign bus_driven = (state == OWN_CYCLE) || (state == OWN_EXPLICIT);
  assign drive_en   = bus_driven;

  assert_req_until_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !xfer_start |=> bus_req);
  assert_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> bus_driven);
endmodule

// File: tb/tb_bus_own_ctrl.sv
module tb_bus_own_ctrl;
  localparam int BEAT_W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, bus_grant = 1'b0, xfer_ack = 1'b0, xfer_err = 1'b0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic req_ready, bus_req, bus_driven, xfer_start, drive_en;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bus_own_ctrl #(.BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_beats(req_beats), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_driven(bus_driven), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
    .xfer_err(xfer_err), .drive_en(drive_en)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
    checks++;
    if (drive_en !== bus_driven) begin
      errors++;
      $display("FAIL R9 drive_en actual=%b expected=%b", drive_en, bus_driven);
    end
  endtask

  task automatic offer(input logic [BEAT_W-1:0] n);
    req_valid = 1'b1; req_beats = n;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R10 bus_req", bus_req, 1'b0);
    chk("R10 bus_driven", bus_driven, 1'b0);
    chk("R10 xfer_start", xfer_start, 1'b0);
    chk("R10 req_ready", req_ready, 1'b1);
  endtask

  task automatic test_start_from_idle();
    offer(4'd0);
    chk("R1 bus_req raised", bus_req, 1'b1);
    chk("R11 ready low while waiting", req_ready, 1'b0);
    req_valid = 1'b1; req_beats = 4'd5;
    tick(); tick();
    req_valid = 1'b0;
    chk("R11 second offer not taken", req_ready, 1'b0);
    chk("R1 bus_req held", bus_req, 1'b1);
    chk("R2 no start without grant", xfer_start, 1'b0);
    bus_grant = 1'b1;
    tick();
    chk("R2 start pulse", xfer_start, 1'b1);
    chk("R2 driven at start", bus_driven, 1'b1);
    chk("R1 bus_req through start", bus_req, 1'b1);
    bus_grant = 1'b0; xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
    chk("R2 single pulse", xfer_start, 1'b0);
    chk("R1 bus_req dropped", bus_req, 1'b0);
    chk("R6 released", bus_driven, 1'b0);
  endtask

  task automatic test_implicit();
    bus_grant = 1'b1;
    tick(); tick(); tick();
    chk("R3 implicit not driven", bus_driven, 1'b0);
    chk("R3 implicit no start", xfer_start, 1'b0);
    bus_grant = 1'b0;
    tick();
    offer(4'd0);
    tick();
    chk("R13 no start after release", xfer_start, 1'b0);
    chk("R13 not driven", bus_driven, 1'b0);
    bus_grant = 1'b1;
    tick();
    chk("R13 start once grant back", xfer_start, 1'b1);
    xfer_ack = 1'b1; bus_grant = 1'b0;
    tick();
    xfer_ack = 1'b0;
    chk("R6 released after single beat", bus_driven, 1'b0);
  endtask

  task automatic test_implicit_to_explicit();
    bus_grant = 1'b1;
    tick(); tick();
    offer(4'd0);
    chk("R4 not yet started", xfer_start, 1'b0);
    tick();
    chk("R4 start from implicit", xfer_start, 1'b1);
    xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
    chk("R5 driven after series", bus_driven, 1'b1);
    tick(); tick();
    chk("R5 still driven", bus_driven, 1'b1);
    chk("R5 no spurious start", xfer_start, 1'b0);
    bus_grant = 1'b0;
    tick();
    chk("R13 released from explicit idle", bus_driven, 1'b0);
  endtask

  task automatic test_burst_release();
    bus_grant = 1'b1;
    offer(4'd3);
    tick();
    chk("R7 burst start", xfer_start, 1'b1);
    bus_grant = 1'b0; xfer_ack = 1'b1;
    tick();
    chk("R6 driven beat1", bus_driven, 1'b1);
    xfer_ack = 1'b0;
    tick();
    chk("R7 wait state keeps drive", bus_driven, 1'b1);
    chk("R7 one start per series", xfer_start, 1'b0);
    xfer_ack = 1'b1;
    tick();
    chk("R6 driven beat2", bus_driven, 1'b1);
    tick();
    chk("R6 driven beat3", bus_driven, 1'b1);
    tick();
    xfer_ack = 1'b0;
    chk("R7 release after beat4", bus_driven, 1'b0);
  endtask

  task automatic test_error();
    bus_grant = 1'b1;
    offer(4'd3);
    tick();
    chk("R8 start", xfer_start, 1'b1);
    xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0; xfer_err = 1'b1;
    tick();
    xfer_err = 1'b0;
    chk("R8 error ends series, grant held", bus_driven, 1'b1);
    offer(4'd3);
    tick();
    chk("R8 restart", xfer_start, 1'b1);
    bus_grant = 1'b0; xfer_err = 1'b1;
    tick();
    xfer_err = 1'b0;
    chk("R8 error releases without grant", bus_driven, 1'b0);
  endtask

  task automatic test_back_to_back();
    bus_grant = 1'b1;
    offer(4'd1);
    tick();
    chk("R12 first start", xfer_start, 1'b1);
    offer(4'd0);
    chk("R12 second waiting", req_ready, 1'b0);
    xfer_ack = 1'b1;
    tick();
    chk("R12 no start mid series", xfer_start, 1'b0);
    tick();
    chk("R12 back-to-back start", xfer_start, 1'b1);
    chk("R12 still driven", bus_driven, 1'b1);
    bus_grant = 1'b0;
    tick();
    xfer_ack = 1'b0;
    chk("R12 released after second", bus_driven, 1'b0);
    chk("R1 request gone", bus_req, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_start_from_idle();
    test_implicit();
    test_implicit_to_explicit();
    test_burst_release();
    test_error();
    test_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule